// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Register Slave

This block is the configuration port of a clock-generator style device. A host on a two-wire serial bus (SCLK and SDATA) writes a frame. The frame holds an address byte, a command byte, a count byte and then a run of data bytes. The block ignores the command and count bytes. It places the data bytes one after another into a small bank of control registers. Those registers drive device functions such as per-output disable, frequency selection, output tristate and test mode. The bank powers up with default contents, so the device works even if the bus is never used.

Both bus lines pass through synchronisers clocked by a faster system clock. Start and stop conditions and SCLK edges are detected from the synchronised samples. The slave never drives SDATA high. It only asserts an open-drain pull-down enable during the acknowledge slot of each byte. No read transfers exist.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cfg_q` equals `REG_DEFAULTS` and `sda_oe` is 0.
- R2: A start is SDATA falling while SCLK is high. A stop is SDATA rising while SCLK is high. Bits are taken on the SCLK rising edge, most significant bit first.
- R3: When the first byte after a start equals `{DEV_ADDR, 1'b0}` (0xD2 by default), `sda_oe` rises after the SCLK fall that ends bit 8. It falls after the SCLK fall that ends the 9th (acknowledge) clock. The same happens for every later byte until a stop.
- R4: When the first byte differs, no acknowledge is given for it or for any further byte, and the registers do not change until the next start.
- R5: The second byte (command) and third byte (count) are acknowledged and change no register.
- R6: The k-th data byte (k = 0, 1, ...) is written to register k, which sits in `cfg_q[8k+7:8k]`. The register changes in the same cycle that `sda_oe` rises for that byte.
- R7: Data bytes beyond the last of the `NREG` registers are acknowledged and discarded.
- R8: Bits set in `RSV_MASK` are always 0 in `cfg_q`. Writing 1 to them stores 0. By default these are bit 7 of register 3 and bits 7:6 of register 2.
- R9: A stop or start that arrives before the 8th bit of a byte is complete aborts that byte without touching any register.
- R10: A repeated start restarts decoding: the next byte is treated as an address and the next data byte goes to register 0.
- R11: `sda_oe` is never asserted while SCLK is high during the eight data-bit clocks of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | Pull SDATA low when 1 (open-drain enable) |
| cfg_q | output | 8*NREG | Register bank image, register k at bits 8k+7:8k |

## Verification
The bench targets the following corner cases:
- Frames longer than the bank. A design that wraps the write index would overwrite register 0.
- Bytes cut short by a stop or a repeated start. A design that writes a partial shift register would corrupt a register.
- A wrong address followed by a byte equal to the right address but with no new start. A slave that re-decodes without a start would acknowledge it.
- Data patterns that are not bit-symmetric. These expose a reversed bit order.
- All-ones writes. These show whether reserved bits are masked.

A per-clock reference comparison of the register image and the pull-down enable catches a write or an acknowledge that lands in the wrong slot.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SKIP
    } slv_state_t;

    localparam int FIRST_DATA_IDX = 3;

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d        = q;
        d.scl_ff = {q.scl_ff[STAGES-2:0], scl_i};
        d.sda_ff = {q.sda_ff[STAGES-2:0], sda_i};
        d.scl_p  = q.scl_ff[STAGES-1];
        d.sda_p  = q.sda_ff[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_ff[STAGES-1];
    assign sda_s     = q.sda_ff[STAGES-1];
    assign start_det = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_det  = scl_s & q.scl_p & ~q.sda_p & sda_s;
endmodule

// File: rtl/cfg_wr_engine.sv
module cfg_wr_engine
    import cfg_slave_pkg::*;
#(
    parameter int         NREG     = 4,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    localparam int        SEL_W    = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int        IDX_W    = $clog2(NREG + FIRST_DATA_IDX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [SEL_W-1:0] wr_sel,
    output logic [7:0]       wr_data
);
    localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(FIRST_DATA_IDX);
    localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(FIRST_DATA_IDX + NREG);

    typedef struct packed {
        slv_state_t       state;
        logic [3:0]       bitcnt;
        logic [7:0]       shreg;
        logic [IDX_W-1:0] idx;
        logic             oe;
        logic             scl_p;
    } eng_t;

    eng_t q, d;
    logic             scl_rise, scl_fall;
    logic [IDX_W-1:0] rel_idx;

    assign scl_rise = scl_s & ~q.scl_p;
    assign scl_fall = ~scl_s & q.scl_p;
    assign rel_idx  = q.idx - IDX_FIRST;

    always_comb begin
        d       = q;
        d.scl_p = scl_s;
        wr_en   = 1'b0;
        wr_sel  = rel_idx[SEL_W-1:0];
        wr_data = q.shreg;
        if (stop_det) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
        end else if (start_det) begin
            d.state  = ST_RECV;
            d.bitcnt = '0;
            d.idx    = '0;
            d.oe     = 1'b0;
        end else begin
            case (q.state)
                ST_RECV: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        if (q.idx == '0 && q.shreg != {DEV_ADDR, 1'b0}) begin
                            d.state = ST_SKIP;
                        end else begin
                            d.state = ST_ACK;
                            d.oe    = 1'b1;
                            wr_en   = (q.idx >= IDX_FIRST) && (q.idx < IDX_END);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe     = 1'b0;
                        d.state  = ST_RECV;
                        d.bitcnt = '0;
                        if (q.idx != IDX_END) d.idx = q.idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.scl_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int                NREG         = 4,
    parameter logic [NREG*8-1:0] REG_DEFAULTS = '0,
    parameter logic [NREG*8-1:0] RSV_MASK     = '0,
    localparam int               SEL_W        = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [7:0]        wr_data,
    output logic [NREG*8-1:0] cfg_q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [7:0] reg_d, reg_q;

        always_comb begin
            reg_d = reg_q;
            if (wr_en && wr_sel == SEL_W'(g)) reg_d = wr_data & ~RSV_MASK[g*8 +: 8];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_q <= REG_DEFAULTS[g*8 +: 8] & ~RSV_MASK[g*8 +: 8];
            else        reg_q <= reg_d;
        end

        assign cfg_q[g*8 +: 8] = reg_q;
    end
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave #(
    parameter int                NREG         = 4,
    parameter logic [6:0]        DEV_ADDR     = 7'h69,
    parameter logic [NREG*8-1:0] REG_DEFAULTS = 32'h1000_0800,
    parameter logic [NREG*8-1:0] RSV_MASK     = 32'h80C0_0000,
    parameter int                SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_q
);
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic             scl_s, sda_s, start_det, stop_det;
    logic             wr_en;
    logic [SEL_W-1:0] wr_sel;
    logic [7:0]       wr_data;

    cfg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_wr_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data)
    );

    cfg_reg_bank #(.NREG(NREG), .REG_DEFAULTS(REG_DEFAULTS), .RSV_MASK(RSV_MASK)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );
endmodule

// File: rtl/clkgen_cfg_slave_chk.sv
module clkgen_cfg_slave_chk #(
    parameter int                NREG         = 4,
    parameter logic [NREG*8-1:0] REG_DEFAULTS = 32'h1000_0800,
    parameter logic [NREG*8-1:0] RSV_MASK     = 32'h80C0_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              stop_det,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg_q
);
    // R1: reset image
    assert_reset_defaults_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == (REG_DEFAULTS & ~RSV_MASK)) && !sda_oe);

    // R3: pull-down is held while SCLK is high in the acknowledge slot
    assert_ack_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && scl_s) |=> sda_oe);

    // R6: the bank only changes when an acknowledge begins
    assert_write_at_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> $rose(sda_oe));

    // R8: reserved bits never set
    assert_reserved_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q & RSV_MASK) == '0);

    // R9: a stop releases the line
    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R11: pull-down starts only while SCLK is low
    assert_oe_rise_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
endmodule

bind clkgen_cfg_slave clkgen_cfg_slave_chk #(
    .NREG(NREG), .REG_DEFAULTS(REG_DEFAULTS), .RSV_MASK(RSV_MASK)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .cfg_q    (cfg_q)
);

// File: tb/test_clkgen_cfg_slave.sv
module test_clkgen_cfg_slave;
    localparam int          NREG = 4;
    localparam logic [31:0] DEF  = 32'h1000_0800;
    localparam logic [31:0] RSV  = 32'h80C0_0000;
    localparam int          QW   = 10;

    logic        clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
    logic        sda_oe, sda_line;
    logic [31:0] cfg;

    assign sda_line = msda & ~sda_oe;
    always #4 clk = ~clk;

    clkgen_cfg_slave i_clkgen_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .cfg_q(cfg)
    );

    int          vec = 0, bad = 0, cyc = 0, last_evt = 0;
    bit          live = 0;
    logic [31:0] exp_cfg = DEF;
    logic        exp_oe = 1'b0;
    string       cur_req = "R1";
    bit          m_on = 0;
    int          m_idx = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // per-clock reference comparison, skipping settling cycles after events
    always @(posedge clk) begin
        #2;
        if (live && (cyc - last_evt) > 6) begin
            vec++;
            if (cfg !== exp_cfg || sda_oe !== exp_oe) begin
                bad++;
                $display("FAIL %s: actual cfg=%h oe=%b expected cfg=%h oe=%b",
                         cur_req, cfg, sda_oe, exp_cfg, exp_oe);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    endtask

    task automatic qw();
        repeat (QW) @(negedge clk);
    endtask

    task automatic mark();
        last_evt = cyc;
    endtask

    function automatic bit model_byte(input logic [7:0] b);
        if (!m_on) return 1'b0;
        if (m_idx == 0) begin
            if (b != 8'hD2) begin
                m_on = 0;
                return 1'b0;
            end
        end else if (m_idx >= 3 && m_idx - 3 < NREG) begin
            exp_cfg[(m_idx-3)*8 +: 8] = b & ~RSV[(m_idx-3)*8 +: 8];
        end
        m_idx++;
        return 1'b1;
    endfunction

    task automatic i2c_start();
        if (scl == 1'b0) begin
            msda = 1'b1; qw();
            scl = 1'b1; qw();
        end
        msda = 1'b0; mark(); qw();
        scl = 1'b0; mark(); qw();
        m_on = 1; m_idx = 0;
    endtask

    task automatic i2c_stop();
        msda = 1'b0; qw();
        scl = 1'b1; qw();
        msda = 1'b1; mark(); qw();
        m_on = 0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            msda = b[7-i]; qw();
            scl = 1'b1; qw();
            chk(sda_oe == 1'b0, "R11", {31'd0, sda_oe}, 32'd0);
            qw();
            scl = 1'b0; mark(); qw();
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        bit ack;
        send_bits(b, 7);
        msda = b[0]; qw();
        scl = 1'b1; qw();
        chk(sda_oe == 1'b0, "R11", {31'd0, sda_oe}, 32'd0);
        qw();
        scl = 1'b0;
        ack = model_byte(b);
        exp_oe = ack; mark(); qw();
        msda = 1'b1; qw();
        scl = 1'b1; qw();
        chk(sda_line == !ack, ack ? "R3" : "R4", {31'd0, sda_line}, {31'd0, !ack});
        qw();
        scl = 1'b0; exp_oe = 1'b0; mark(); qw();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(cfg == DEF, "R1", cfg, DEF);
        chk(sda_oe == 1'b0, "R1", {31'd0, sda_oe}, 32'd0);
        rst_n = 1'b1; mark(); live = 1;
        qw();
        chk(cfg == DEF, "R1", cfg, DEF);

        // full frame, non-symmetric data and all-ones into reserved bits
        cur_req = "R6";
        i2c_start();
        send_byte(8'hD2); send_byte(8'h3A); send_byte(8'h04);
        send_byte(8'hA5); send_byte(8'h5A); send_byte(8'hFF); send_byte(8'hFF);
        i2c_stop(); qw();
        chk(cfg == 32'h7F3F_5AA5, "R2", cfg, 32'h7F3F_5AA5);
        chk(cfg == 32'h7F3F_5AA5, "R8", cfg, 32'h7F3F_5AA5);

        // overflow past the last register
        cur_req = "R7";
        i2c_start();
        send_byte(8'hD2); send_byte(8'h00); send_byte(8'h02);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        send_byte(8'h55); send_byte(8'h66);
        i2c_stop(); qw();
        chk(cfg == 32'h4433_2211, "R7", cfg, 32'h4433_2211);

        // wrong address and read bit
        cur_req = "R4";
        i2c_start();
        send_byte(8'hD0); send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        i2c_stop();
        i2c_start();
        send_byte(8'hD3); send_byte(8'hD2); send_byte(8'h00); send_byte(8'h00); send_byte(8'h99);
        i2c_stop(); qw();
        chk(cfg == 32'h4433_2211, "R4", cfg, 32'h4433_2211);

        // command and count only
        cur_req = "R5";
        i2c_start();
        send_byte(8'hD2); send_byte(8'hEE); send_byte(8'hEE);
        i2c_stop(); qw();
        chk(cfg == 32'h4433_2211, "R5", cfg, 32'h4433_2211);

        // aborted bytes
        cur_req = "R9";
        i2c_start();
        send_byte(8'hD2); send_byte(8'h00); send_byte(8'h00);
        send_bits(8'h99, 5);
        i2c_stop(); qw();
        chk(cfg == 32'h4433_2211, "R9", cfg, 32'h4433_2211);
        i2c_start();
        send_byte(8'hD2); send_byte(8'h00); send_byte(8'h00);
        send_bits(8'h77, 3);
        cur_req = "R10";
        i2c_start();
        send_byte(8'hD2); send_byte(8'h00); send_byte(8'h00); send_byte(8'h12);
        i2c_stop(); qw();
        chk(cfg == 32'h4433_2212, "R10", cfg, 32'h4433_2212);

        // repeated start after a mismatch
        i2c_start();
        send_byte(8'hAA);
        i2c_start();
        send_byte(8'hD2); send_byte(8'h00); send_byte(8'h02);
        send_byte(8'h01); send_byte(8'h02);
        i2c_stop(); qw();
        chk(cfg == 32'h4433_0201, "R10", cfg, 32'h4433_0201);

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1..: actual hung expected finished");
        summary();
        $finish;
    end
endmodule